// File: doc/BRIEF.md
# ROM XOR Checksum Verifier

This block is a power-on self-test engine for a byte-wide program ROM. After a start pulse it walks a fixed-length region of the ROM from a configurable base address, one address per clock. It folds every returned byte into a running bitwise XOR and, once the last byte is in, gives its verdict. An image is good when the last byte holds the XOR of all the bytes before it, so that the fold over the whole region comes to zero.

A nonzero fold means the image is corrupt. The engine then raises a sticky halt flag and puts a fixed checkpoint code on an 8-bit diagnostic port, so that a failure can be seen from the pins alone. The ROM is read synchronously, and the engine lines up each returned byte with the address issued one cycle earlier. The verdict stays in place until reset or the next accepted start.

Top module: `rom_xor_checker`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, halt_o and rom_rd_o are 0 and diag_o is 0x00.
- R2: A start pulse taken while idle makes busy_o high from the next cycle. The engine then drives rom_rd_o high for exactly REGION_LEN consecutive cycles, with rom_addr_o going BASE_ADDR, BASE_ADDR+1, ... BASE_ADDR+REGION_LEN-1 in that order.
- R3: The byte on rom_data_i one cycle after each address is issued is folded into the XOR. This covers every byte in the region, the first and the last included, and a single bad byte anywhere makes the check fail.
- R4: done_o is high for exactly one cycle. It rises on the (REGION_LEN+1)-th rising edge after the edge that takes the start, and in the same cycle busy_o falls.
- R5: When the final XOR is zero, pass_o=1, halt_o=0 and diag_o=0x00 from the cycle in which done_o is high.
- R6: When the final XOR is nonzero, halt_o=1, pass_o=0 and diag_o=0x01 (the checkpoint code) from the cycle in which done_o is high.
- R7: pass_o, halt_o and diag_o keep their values until reset or an accepted start. An accepted start clears all three in the next cycle.
- R8: A start pulse while busy_o is high is ignored. The address sequence does not restart, and done_o and the verdict come at the same time and with the same value as without the pulse.
- R9: A start pulse in the cycle where done_o is high is accepted and begins a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| rom_rd_o | output | 1 | ROM read enable |
| rom_addr_o | output | ADDR_W | ROM byte address |
| rom_data_i | input | 8 | ROM read data, one cycle after the address |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle pulse when the verdict is made |
| pass_o | output | 1 | Image good (latched) |
| halt_o | output | 1 | Image bad, sticky halt (latched) |
| diag_o | output | 8 | Checkpoint code: 0x01 on failure, else 0x00 |

## Verification
Two events can land on the same clock edge. One is a new start request, and the other is the final comparison or the done pulse that follows it. The bench raises start during the last cycle before the comparison edge, while the engine is still busy, and checks that the request is dropped without disturbing the verdict or its timing. It then raises start in the very cycle done is high. The bench judges that case by the cleared pass, halt and code one cycle later, the rise of busy, and a complete, correctly ordered second pass with a correct result.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/rcs_addr_seq.sv
module rcs_addr_seq
   import rcs_pkg::*;
#(
   parameter int unsigned              ADDR_W     = 16,
   parameter int unsigned              REGION_LEN = 8192,
   parameter logic [ADDR_W-1:0]        BASE_ADDR  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              fin_i,
   output logic              accept_o,
   output logic              rd_o,
   output logic              last_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              busy_o
);
   localparam int unsigned       CNT_W     = (REGION_LEN > 1) ? $clog2(REGION_LEN) : 1;
   localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(REGION_LEN - 1);
   localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(REGION_LEN - 1);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept_o = start_i && (state_q == SEQ_IDLE);
   assign rd_o     = (state_q == SEQ_RUN);
   assign last_o   = rd_o && (cnt_q == CNT_LAST);
   assign addr_o   = BASE_ADDR + ADDR_W'(cnt_q);
   assign busy_o   = (state_q != SEQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: if (accept_o) begin
               state_q <= SEQ_RUN;
               cnt_q   <= '0;
            end
            SEQ_RUN: begin
               if (last_o) state_q <= SEQ_WAIT;
               else        cnt_q   <= cnt_q + 1'b1;
            end
            SEQ_WAIT: if (fin_i) state_q <= SEQ_IDLE;
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_o && !last_o) |=> (rd_o && addr_o == $past(addr_o) + ADDR_W'(1)));

   assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o |-> (addr_o >= BASE_ADDR && addr_o <= LAST_ADDR));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == SEQ_RUN) |=> (state_q != SEQ_IDLE));

endmodule

// File: rtl/rcs_lat_pipe.sv
module rcs_lat_pipe #(
   parameter int unsigned READ_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic last_i,
   output logic vld_o,
   output logic last_o
);
   if (READ_LAT == 1) begin : g_single
      logic vld_q, last_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            last_q <= 1'b0;
         end else begin
            vld_q  <= vld_i;
            last_q <= last_i;
         end
      end
      assign vld_o  = vld_q;
      assign last_o = last_q;
   end else begin : g_chain
      logic [READ_LAT-1:0] vld_sr, last_sr;
      for (genvar s = 0; s < READ_LAT; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_sr[s]  <= 1'b0;
               last_sr[s] <= 1'b0;
            end else if (s == 0) begin
               vld_sr[s]  <= vld_i;
               last_sr[s] <= last_i;
            end else begin
               vld_sr[s]  <= vld_sr[s-1];
               last_sr[s] <= last_sr[s-1];
            end
         end
      end
      assign vld_o  = vld_sr[READ_LAT-1];
      assign last_o = last_sr[READ_LAT-1];
   end

endmodule

// File: rtl/rcs_fold.sv
module rcs_fold
   import rcs_pkg::*;
#(
   parameter logic [BYTE_W-1:0] CHECKPOINT = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              vld_i,
   input  logic              last_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              done_o,
   output logic              pass_o,
   output logic              halt_o,
   output logic [BYTE_W-1:0] diag_o
);
   logic [BYTE_W-1:0] acc_q;
   logic [BYTE_W-1:0] acc_nxt;
   logic              fin;

   assign acc_nxt = acc_q ^ data_i;
   assign fin     = vld_i && last_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         done_o <= 1'b0;
         pass_o <= 1'b0;
         halt_o <= 1'b0;
         diag_o <= '0;
      end else begin
         done_o <= fin;
         if (clear_i) begin
            acc_q  <= '0;
            pass_o <= 1'b0;
            halt_o <= 1'b0;
            diag_o <= '0;
         end else if (vld_i) begin
            acc_q <= acc_nxt;
            if (last_i) begin
               pass_o <= (acc_nxt == '0);
               halt_o <= (acc_nxt != '0);
               diag_o <= (acc_nxt != '0) ? CHECKPOINT : '0;
            end
         end
      end
   end

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_halt_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> (diag_o == CHECKPOINT && !pass_o));

   assert_pass_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> (!halt_o && diag_o == '0));

   assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !fin) |=> ($stable(pass_o) && $stable(halt_o) && $stable(diag_o)));

endmodule

// File: rtl/rom_xor_checker.sv
module rom_xor_checker
   import rcs_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 16,
   parameter int unsigned        REGION_LEN = 8192,
   parameter logic [ADDR_W-1:0]  BASE_ADDR  = 16'hE000,
   parameter int unsigned        READ_LAT   = 1,
   parameter logic [7:0]         CHECKPOINT = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rom_rd_o,
   output logic [ADDR_W-1:0] rom_addr_o,
   input  logic [7:0]        rom_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              halt_o,
   output logic [7:0]        diag_o
);
   if (REGION_LEN < 2) begin : g_bad_len
      $error("REGION_LEN must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 31) begin : g_bad_aw
      $error("ADDR_W must lie in 1..31");
   end
   if (longint'(BASE_ADDR) + longint'(REGION_LEN) > (longint'(1) << ADDR_W)) begin : g_bad_span
      $error("region runs past the top of the address space");
   end
   if (READ_LAT < 1) begin : g_bad_lat
      $error("READ_LAT must be at least 1");
   end
   if (CHECKPOINT == 8'h00) begin : g_bad_code
      $error("CHECKPOINT must be nonzero");
   end

   logic accept;
   logic issue_last;
   logic dat_vld, dat_last;

   rcs_addr_seq #(
      .ADDR_W    (ADDR_W),
      .REGION_LEN(REGION_LEN),
      .BASE_ADDR (BASE_ADDR)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .fin_i   (dat_vld && dat_last),
      .accept_o(accept),
      .rd_o    (rom_rd_o),
      .last_o  (issue_last),
      .addr_o  (rom_addr_o),
      .busy_o  (busy_o)
   );

   rcs_lat_pipe #(
      .READ_LAT(READ_LAT)
   ) i_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (rom_rd_o),
      .last_i(issue_last),
      .vld_o (dat_vld),
      .last_o(dat_last)
   );

   rcs_fold #(
      .CHECKPOINT(CHECKPOINT)
   ) i_fold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(accept),
      .vld_i  (dat_vld),
      .last_i (dat_last),
      .data_i (rom_data_i),
      .done_o (done_o),
      .pass_o (pass_o),
      .halt_o (halt_o),
      .diag_o (diag_o)
   );

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_accept_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !pass_o && !halt_o && diag_o == 8'h00));

endmodule

// File: tb/test_rom_xor_checker.sv
module test_rom_xor_checker;
   localparam int         CLK_PERIOD = 10;
   localparam int         LEN        = 64;
   localparam int         AW         = 16;
   localparam logic [15:0] BASE      = 16'h0F00;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rom_rd;
   logic [AW-1:0] rom_addr;
   logic [7:0]    rom_data = 8'h00;
   logic          busy, done, pass, halt;
   logic [7:0]    diag;

   int checks = 0;
   int fails  = 0;
   int seed = 1;
   int bad_idx = -1;
   logic [7:0] bad_mask = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   rom_xor_checker #(
      .ADDR_W(AW), .REGION_LEN(LEN), .BASE_ADDR(BASE), .READ_LAT(1), .CHECKPOINT(8'h01)
   ) i_rom_xor_checker (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .rom_rd_o(rom_rd), .rom_addr_o(rom_addr), .rom_data_i(rom_data),
      .busy_o(busy), .done_o(done), .pass_o(pass), .halt_o(halt), .diag_o(diag)
   );

   function automatic logic [7:0] pat(int i, int s);
      return 8'((i * 37 + s * 11) ^ (i >> 2) ^ s);
   endfunction

   function automatic logic [7:0] chk_byte(int s);
      logic [7:0] x = 8'h00;
      for (int i = 0; i < LEN - 1; i++) x ^= pat(i, s);
      return x;
   endfunction

   function automatic logic [7:0] img(int i);
      logic [7:0] v;
      v = (i == LEN - 1) ? chk_byte(seed) : pat(i, seed);
      if (i == bad_idx) v ^= bad_mask;
      return v;
   endfunction

   // ROM model: one cycle read latency
   always @(posedge clk) begin
      if (rom_rd) rom_data <= img(int'(rom_addr) - int'(BASE));
   end

   // address order monitor
   logic prev_rd = 1'b0;
   int   rd_idx = 0;
   int   addr_err = 0;
   always @(negedge clk) begin
      if (rom_rd) begin
         if (!prev_rd) rd_idx = 0;
         if (rom_addr !== BASE + AW'(rd_idx)) addr_err++;
         rd_idx++;
      end
      prev_rd = rom_rd;
   end

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // Start a pass from idle; poke_a/poke_b: edge counts at which start is raised again.
   task automatic run_pass(input int poke_a, input int poke_b, output int edges);
      addr_err = 0;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      edges = 0;
      check("R2", "busy after accept", busy, 1);
      check("R7", "verdict cleared after accept", {pass, halt, diag}, 0);
      while (!done && edges < LEN + 20) begin
         start = (edges == poke_a) || (edges == poke_b);
         @(posedge clk);
         edges++;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "busy/done/pass/halt/rd", {busy, done, pass, halt, rom_rd}, 0);
      check("R1", "diag", diag, 8'h00);
   endtask

   task automatic t_good();
      int e;
      seed = 5; bad_idx = -1; bad_mask = 8'h00;
      run_pass(-1, -1, e);
      check("R4", "done latency", e, LEN + 1);
      check("R4", "busy falls with done", busy, 0);
      check("R2", "read count", rd_idx, LEN);
      check("R2", "address order", addr_err, 0);
      check("R5", "pass/halt/diag", {pass, halt, diag}, {1'b1, 1'b0, 8'h00});
      @(negedge clk);
      check("R4", "done one cycle", done, 0);
   endtask

   task automatic t_bad(input int idx, input logic [7:0] mask, input string tag);
      int e;
      seed = 9; bad_idx = idx; bad_mask = mask;
      run_pass(-1, -1, e);
      check("R6", {tag, " halt/pass"}, {halt, pass}, 2'b10);
      check("R6", {tag, " checkpoint code"}, diag, 8'h01);
      check("R3", {tag, " latency"}, e, LEN + 1);
   endtask

   task automatic t_hold();
      repeat (25) @(negedge clk);
      check("R7", "halt held", halt, 1);
      check("R7", "code held", diag, 8'h01);
      check("R7", "pass held low", pass, 0);
   endtask

   task automatic t_start_busy();
      int e;
      seed = 3; bad_idx = -1;
      // second poke lands in the cycle before the final comparison edge
      run_pass(10, LEN, e);
      check("R8", "latency unchanged", e, LEN + 1);
      check("R8", "no restart in address walk", addr_err, 0);
      check("R8", "read count", rd_idx, LEN);
      check("R8", "verdict", {pass, halt}, 2'b10);
   endtask

   task automatic t_start_on_done();
      int e;
      seed = 7; bad_idx = 30; bad_mask = 8'h04;
      run_pass(-1, -1, e);
      check("R9", "first verdict fail", {done, halt}, 2'b11);
      seed = 12; bad_idx = -1;
      run_pass(-1, -1, e);
      check("R9", "second pass latency", e, LEN + 1);
      check("R9", "second pass addresses", addr_err, 0);
      check("R9", "second verdict", {pass, halt, diag}, {1'b1, 1'b0, 8'h00});
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good();
      t_bad(20, 8'h10, "middle byte");
      t_hold();
      t_bad(0, 8'h01, "first byte");
      t_bad(LEN - 1, 8'h80, "last byte");
      t_start_busy();
      t_start_on_done();
      summary();
   end

endmodule